// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It uses two levels of state. The first level is branch history. Either one shared shift register records the outcomes of the most recent branches of any address, or a small table records the recent outcomes of each branch separately. An input picks which of the two supplies the history. The second level is a table of saturating counters. Each counter is selected by the chosen history pattern joined with the low bits of the branch address. Its top bit gives the prediction.

The front end presents a branch address on the lookup side and receives the predicted direction combinationally in the same cycle. When a branch resolves, the back end presents its address and real outcome on the update side. The counter selected by the history as it stood before the update moves one step toward that outcome. Both history structures then shift the outcome in.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and every history is 0000, so every lookup in either mode predicts not-taken until an update occurs.
- R2: The prediction is taken when the selected 2-bit counter is 10 or 11, and not-taken when it is 00 or 01.
- R3: An update with outcome taken raises the selected counter by one, stopping at 11. An update with outcome not-taken lowers it by one, stopping at 00.
- R4: A counter at 11 needs two consecutive not-taken updates before its prediction changes to not-taken.
- R5: When `use_local` is 0, the counter index is {global history[3:0], addr[1:0]}. The global history holds the outcomes of the last four updates of any address, with the newest outcome in bit 0.
- R6: When `use_local` is 1, the counter index is {local history[3:0], addr[1:0]}. The local history is one of 16 entries chosen by addr[3:0], and each entry holds the last four outcomes of updates that map to it, newest in bit 0.
- R7: An update changes the counter selected by the history as it was before that update. The outcome is shifted into the history only afterwards.
- R8: A lookup is combinational. An update in the same cycle does not affect that cycle's prediction, and is visible from the next cycle on.
- R9: In a cycle without `up_valid`, no counter and no history changes.
- R10: Every update shifts its outcome into both the global history and the local entry of its address, whichever mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| use_local | input | 1 | History select: 0 global, 1 per-branch |
| lk_addr | input | 32 | Address of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The prediction is due in the same cycle as the lookup address, with no register between them. An update is due one clock edge later, so it first appears in the cycle after it is presented. The bench drives every input just after the falling edge and samples `lk_taken` two nanoseconds later. Only on the following rising edge does it apply that cycle's update to its behavioural model, so each compare sees exactly the state left by earlier cycles. Directed sequences that bring the global history back to 0000 check the counter steps, the old-history indexing and the two-miss hysteresis against fixed values. A long mixed run then compares every cycle against the model in both modes.

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int ADDR_W      = 32,
  parameter int HIST_W      = 4,
  parameter int CTR_W       = 2,
  parameter int LHT_ENTRIES = 16,
  parameter int PC_IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_local,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  localparam int LHT_W = $clog2(LHT_ENTRIES);
  localparam int PHT_W = HIST_W + PC_IDX_W;
  localparam int PHT_N = 1 << PHT_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

  logic [HIST_W-1:0] ghist;
  logic [HIST_W-1:0] lht [LHT_ENTRIES];
  logic [CTR_W-1:0]  pht [PHT_N];

  logic [LHT_W-1:0]  lk_lidx, up_lidx;
  logic [HIST_W-1:0] lk_hist, up_hist;
  logic [PHT_W-1:0]  lk_idx, up_idx;
  logic [CTR_W-1:0]  up_ctr, up_ctr_nxt;

  assign lk_lidx  = lk_addr[LHT_W-1:0];
  assign lk_hist  = use_local ? lht[lk_lidx] : ghist;
  assign lk_idx   = {lk_hist, lk_addr[PC_IDX_W-1:0]};
  assign lk_taken = pht[lk_idx][CTR_W-1];

  assign up_lidx  = up_addr[LHT_W-1:0];
  assign up_hist  = use_local ? lht[up_lidx] : ghist;
  assign up_idx   = {up_hist, up_addr[PC_IDX_W-1:0]};
  assign up_ctr   = pht[up_idx];

  always_comb begin
    up_ctr_nxt = up_ctr;
    if (up_taken && up_ctr != CTR_MAX)       up_ctr_nxt = up_ctr + 1'b1;
    else if (!up_taken && up_ctr != CTR_MIN) up_ctr_nxt = up_ctr - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ghist <= '0;
      for (int i = 0; i < LHT_ENTRIES; i++) lht[i] <= '0;
      for (int j = 0; j < PHT_N; j++)       pht[j] <= CTR_INIT;
    end else if (up_valid) begin
      pht[up_idx]  <= up_ctr_nxt;
      ghist        <= {ghist[HIST_W-2:0], up_taken};
      lht[up_lidx] <= {lht[up_lidx][HIST_W-2:0], up_taken};
    end
  end

  // R3
  ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && up_ctr == CTR_MAX) |=> pht[$past(up_idx)] == CTR_MAX);

  // R3
  ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && up_ctr == CTR_MIN) |=> pht[$past(up_idx)] == CTR_MIN);

  // R9
  idle_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));

  // R8
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid ##1 ($stable(lk_addr) && $stable(use_local)) |-> $stable(lk_taken));

  // R10
  ghist_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[0] == $past(up_taken));

  // R1
  reset_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_taken);
endmodule

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        use_local = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_taken;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int pht_m [64];
  int gh_m;
  int lh_m [16];

  always #4 clk = ~clk;

  corr_bpred dut_i (
    .clk(clk), .rst_n(rst_n), .use_local(use_local),
    .lk_addr(lk_addr), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken)
  );

  function automatic int m_idx(bit mode, logic [31:0] a);
    int h;
    h = mode ? lh_m[a % 16] : gh_m;
    return h * 4 + int'(a % 4);
  endfunction

  function automatic bit m_pred(bit mode, logic [31:0] a);
    return pht_m[m_idx(mode, a)] >= 2;
  endfunction

  task automatic m_update(bit mode, logic [31:0] a, bit t);
    int i;
    i = m_idx(mode, a);
    if (t && pht_m[i] < 3) pht_m[i]++;
    if (!t && pht_m[i] > 0) pht_m[i]--;
    gh_m = (gh_m * 2 + int'(t)) % 16;
    lh_m[a % 16] = (lh_m[a % 16] * 2 + int'(t)) % 16;
  endtask

  task automatic m_reset();
    for (int i = 0; i < 64; i++) pht_m[i] = 1;
    for (int i = 0; i < 16; i++) lh_m[i] = 0;
    gh_m = 0;
  endtask

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: lk_taken got %0b expected %0b", tag, act, exp);
    end
  endtask

  // exp: -1 compare with model only, else also with fixed value
  task automatic step(bit mode, logic [31:0] la, bit uv, logic [31:0] ua, bit ut,
                      string tag, int exp);
    @(negedge clk);
    use_local = mode; lk_addr = la; up_valid = uv; up_addr = ua; up_taken = ut;
    #2;
    check(tag, lk_taken, m_pred(mode, la));
    if (exp >= 0) check(tag, lk_taken, exp[0]);
    @(posedge clk);
    if (uv) m_update(mode, ua, ut);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, both modes
    for (int a = 0; a < 20; a += 3) begin
      step(0, a, 0, 0, 0, "R1", 0);
      step(1, a, 0, 0, 0, "R1", 0);
    end

    // R7: taken at ghist 0000 on addr 1 hits the old-history counter
    step(0, 1, 1, 1, 1, "R7", 0);
    step(0, 1, 0, 0, 0, "R7", 0);   // ghist 0001: entry still 01
    for (int k = 0; k < 4; k++) step(0, 2, 1, 2, 0, "R5", -1);
    step(0, 1, 0, 0, 0, "R7", 1);   // ghist 0000 again: entry now 10

    // R3/R4: saturate entry {0000,00} at 11, then two misses
    for (int r = 0; r < 3; r++) begin
      step(0, 0, 1, 0, 1, "R3", -1);
      for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, "R3", -1);
    end
    step(0, 0, 0, 0, 0, "R2", 1);
    step(0, 0, 1, 0, 0, "R8", 1);   // update not visible in same cycle
    step(0, 0, 0, 0, 0, "R4", 1);   // one miss: still taken
    step(0, 0, 1, 0, 0, "R8", 1);
    step(0, 0, 0, 0, 0, "R4", 0);   // second miss: not-taken

    // R9: idle cycles leave predictions unchanged
    for (int k = 0; k < 8; k++) step(k % 2, k, 0, 5, 1, "R9", -1);
    step(0, 0, 0, 0, 0, "R9", 0);

    // R6/R10: per-branch history with interleaved branches
    for (int k = 0; k < 12; k++) begin
      step(1, 5, 1, 5, 1, "R6", -1);
      step(1, 6, 1, 6, 0, "R6", -1);
      step(0, 5, 1, 9, k % 2, "R10", -1);
    end
    step(1, 5, 0, 0, 0, "R6", 1);

    // Mixed run, model compare every cycle
    for (int k = 0; k < 4000; k++) begin
      bit m;
      m = ($urandom % 64 == 0) ? ~use_local : use_local;
      step(m, $urandom % 32, ($urandom % 3) != 0, $urandom % 32, $urandom % 2,
           m ? "R6" : "R5", -1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule